// File: doc/BRIEF.md
# Serial CRC Divider (Generate and Check)

This block divides a serial bit stream by a generator polynomial in modulo-2 arithmetic and keeps the k-bit remainder in a shift register. The generator's degree k and its lower coefficients are parameters; the x^k term is implied. Each accepted bit shifts into the register. When the bit that leaves the top of the register is 1, the feedback XORs the generator taps into the register, so a subtraction takes place only when the leading bit is set.

In generate mode the sender streams its message. After the final bit the block shifts in k zero bits by itself, and it holds `ready_o` low while it does so. The remainder that results is the check sequence to transmit after the message. In check mode the receiver streams the whole received word, message and appended check sequence, and `pass_o` reports whether the division leaves nothing behind. A frame begins with a beat marked `start_i` and ends with a beat marked `last_i`. `done_o` marks the cycle in which the final remainder is on `rem_o`.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset the remainder register is all zeros, `ready_o` is 1, and `done_o` and `pass_o` are 0.
- R2: A bit is accepted when `valid_i` and `ready_o` are both 1. Bits enter MSB first. Each accepted bit performs one long-division step: the register shifts up by one with the new bit at bit 0, and the generator's lower coefficients are XORed in when the old top bit was 1.
- R3: When `mode_i`=0 (generate), the frame's last beat is followed by exactly K cycles with `ready_o`=0, during which K zero bits are shifted in. The result is the remainder of message·x^K divided by the generator. For generator 1101 and message 10011010 this remainder is 101.
- R4: `done_o` is a single-cycle pulse in the cycle after the final shift: one cycle after the last beat in check mode, and K+1 cycles after it in generate mode. After the pulse `rem_o` holds its value until the next accepted bit.
- R5: When `mode_i`=1 (check), `pass_o` is 1 together with `done_o` exactly when the remainder of the whole received word is zero. With generator 1101, the word 10011010101 passes and the word 10010110101 fails with remainder 101.
- R6: Cycles with `valid_i`=0, and beats offered while `ready_o`=0, change neither the remainder nor the frame in progress. This holds even when `start_i` or `last_i` is set on those beats.
- R7: An accepted beat with `start_i`=1 discards all earlier state, including a frame that has not finished, and divides from a zero register. The mode is sampled on that beat and holds for the whole frame.
- R8: The default parameters select the 16-bit generator x^16+x^12+x^5+1, with lower coefficients 16'h1021. With these defaults the ASCII string "123456789" generates 16'h31C3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = generate, 1 = check; sampled on the start beat |
| bit_i | input | 1 | Serial data bit |
| valid_i | input | 1 | Data bit is offered this cycle |
| start_i | input | 1 | Beat is the first bit of a frame |
| last_i | input | 1 | Beat is the final bit of a frame |
| ready_o | output | 1 | Block accepts a beat this cycle |
| rem_o | output | K | Current remainder register |
| done_o | output | 1 | Final remainder is on rem_o (one-cycle pulse) |
| pass_o | output | 1 | Check-mode frame ended with a zero remainder |

## Verification
The assertions assume that the reset is applied before the first frame and that nothing drives beats while the block is in reset. They do not assume that the sender respects `ready_o`. Because of this, the stimulus deliberately offers beats, start markers and last markers during the zero-insertion cycles and in cycles with `valid_i` low, and the register-hold property still has to hold there. The stimulus also starts new frames over unfinished ones and changes `mode_i` in the middle of a frame, so the frame-restart and mode-sampling rules are exercised directly.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } crc_mode_e;

  typedef enum logic {
    ST_TAKE  = 1'b0,
    ST_FLUSH = 1'b1
  } crc_state_e;

endpackage

// File: rtl/crc_div_reg.sv
module crc_div_reg #(
  parameter int           K    = 16,
  parameter logic [K-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         clr,
  input  logic         bit_in,
  output logic [K-1:0] rem_o,
  output logic         rem_zero_o
);

  // One long-division step: shift in the new bit and subtract (XOR) the
  // generator when the bit leaving the top is set.
  function automatic logic [K-1:0] div_step(input logic [K-1:0] r, input logic b);
    logic [K-1:0] shifted;
    shifted  = {r[K-2:0], b};
    div_step = r[K-1] ? (shifted ^ POLY) : shifted;
  endfunction

  logic [K-1:0] rem_q;
  logic [K-1:0] base;
  logic [K-1:0] rem_next;

  assign base     = clr ? '0 : rem_q;
  assign rem_next = div_step(base, bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem_q <= '0;
    else if (shift_en) rem_q <= rem_next;
  end

  assign rem_o      = rem_q;
  assign rem_zero_o = (rem_q == '0);

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(rem_q));

  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && clr) |=> (rem_q[K-1:1] == '0));

endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_serial_pkg::*;
#(
  parameter int K = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic bit_i,
  input  logic valid_i,
  input  logic start_i,
  input  logic last_i,
  output logic ready_o,
  output logic shift_en_o,
  output logic clr_o,
  output logic shift_bit_o,
  output logic done_o,
  output logic chk_mode_o
);

  localparam int CW = $clog2(K + 1);
  localparam logic [CW-1:0] FLUSH_END = CW'(K - 1);

  crc_state_e state_q;
  crc_mode_e  mode_q;
  crc_mode_e  beat_mode;
  logic [CW-1:0] cnt_q;
  logic done_q;

  // Named internal events
  logic take;
  logic last_take;
  logic flushing;
  logic flush_end;

  assign ready_o    = (state_q == ST_TAKE);
  assign take       = valid_i && ready_o;
  assign last_take  = take && last_i;
  assign flushing   = (state_q == ST_FLUSH);
  assign flush_end  = flushing && (cnt_q == FLUSH_END);
  assign beat_mode  = start_i ? crc_mode_e'(mode_i) : mode_q;

  assign shift_en_o  = take || flushing;
  assign clr_o       = take && start_i;
  assign shift_bit_o = flushing ? 1'b0 : bit_i;
  assign done_o      = done_q;
  assign chk_mode_o  = (mode_q == MODE_CHK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TAKE;
      mode_q  <= MODE_GEN;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take && start_i) mode_q <= crc_mode_e'(mode_i);
      if (flushing) begin
        if (flush_end) begin
          state_q <= ST_TAKE;
          cnt_q   <= '0;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (last_take) begin
        if (beat_mode == MODE_GEN) begin
          state_q <= ST_FLUSH;
          cnt_q   <= '0;
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_flush_gen_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (mode_q == MODE_GEN));

  assert_flush_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_end |=> (ready_o && done_o));

  assert_no_done_in_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !done_o);

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
  parameter int           K    = 16,
  parameter logic [K-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic         bit_i,
  input  logic         valid_i,
  input  logic         start_i,
  input  logic         last_i,
  output logic         ready_o,
  output logic [K-1:0] rem_o,
  output logic         done_o,
  output logic         pass_o
);

  logic shift_en;
  logic clr;
  logic shift_bit;
  logic chk_mode;
  logic rem_zero;

  crc_frame_ctrl #(.K(K)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .bit_i       (bit_i),
    .valid_i     (valid_i),
    .start_i     (start_i),
    .last_i      (last_i),
    .ready_o     (ready_o),
    .shift_en_o  (shift_en),
    .clr_o       (clr),
    .shift_bit_o (shift_bit),
    .done_o      (done_o),
    .chk_mode_o  (chk_mode)
  );

  crc_div_reg #(.K(K), .POLY(POLY)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .clr        (clr),
    .bit_in     (shift_bit),
    .rem_o      (rem_o),
    .rem_zero_o (rem_zero)
  );

  assign pass_o = done_o && chk_mode && rem_zero;

  assert_pass_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (done_o && rem_o == '0));

  assert_rem_holds_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !(valid_i && ready_o)) |=> $stable(rem_o));

endmodule

// File: tb/test_crc_serial_unit.sv
module test_crc_serial_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_d = 1'b0, bit_d = 1'b0, valid_d = 1'b0, start_d = 1'b0, last_d = 1'b0;

  logic        rdy_a, done_a, pass_a;
  logic [15:0] rem_a;
  logic        rdy_b, done_b, pass_b;
  logic [2:0]  rem_b;

  always #10 clk = ~clk;

  crc_serial_unit i_crc_serial_unit (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_d), .bit_i(bit_d), .valid_i(valid_d),
    .start_i(start_d), .last_i(last_d), .ready_o(rdy_a), .rem_o(rem_a),
    .done_o(done_a), .pass_o(pass_a)
  );

  crc_serial_unit #(.K(3), .POLY(3'b101)) i_crc_serial_unit_k3 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_d), .bit_i(bit_d), .valid_i(valid_d),
    .start_i(start_d), .last_i(last_d), .ready_o(rdy_b), .rem_o(rem_b),
    .done_o(done_b), .pass_o(pass_b)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic msg [0:255];
  int   msg_n;
  int   lat, rdy_low;
  logic [15:0] got_rem;
  logic        got_pass;

  localparam logic [16:0] GEN_A = 17'h11021;
  localparam logic [16:0] GEN_B = 17'h0000D;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  // Reference: polynomial long division over a bit array, leading bit first.
  function automatic logic [15:0] ref_div(input logic [16:0] gen, input int k, input bit augment);
    logic w [0:300];
    int len;
    logic [15:0] r;
    len = msg_n + (augment ? k : 0);
    for (int i = 0; i < 301; i++) w[i] = (i < msg_n) ? msg[i] : 1'b0;
    for (int i = 0; i + k < len; i++)
      if (w[i])
        for (int j = 0; j <= k; j++) w[i+j] = w[i+j] ^ gen[k-j];
    r = '0;
    for (int i = len - k; i < len; i++) r = {r[14:0], w[i]};
    return r;
  endfunction

  task automatic clear_msg(); msg_n = 0; endtask
  task automatic push_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin msg[msg_n] = v[i]; msg_n++; end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(rdy_a && rdy_b)) @(negedge clk);
  endtask

  task automatic drive_frame(input bit sel, input bit md, input int gap, input bit noise, input bit flip);
    for (int i = 0; i < msg_n; i++) begin
      @(negedge clk);
      while (!(sel ? rdy_b : rdy_a)) begin valid_d = 0; @(negedge clk); end
      mode_d = (flip && i > 0) ? ~md : md;
      valid_d = 1; start_d = (i == 0); last_d = (i == msg_n - 1); bit_d = msg[i];
      if (gap > 0) begin
        @(negedge clk);
        valid_d = 0; start_d = 1; last_d = 1; bit_d = ~bit_d;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    valid_d = 0; start_d = 0; last_d = 0; mode_d = md;
    lat = 1; rdy_low = 0;
    while (!(sel ? done_b : done_a) && lat < 200) begin
      if (!(sel ? rdy_b : rdy_a)) begin
        rdy_low++;
        if (noise) begin valid_d = 1; start_d = 1; last_d = 1; bit_d = 1; end
      end
      @(negedge clk);
      lat++;
    end
    valid_d = 0; start_d = 0; last_d = 0;
    got_rem  = sel ? {13'b0, rem_b} : rem_a;
    got_pass = sel ? pass_b : pass_a;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rem_a == 0 && rem_b == 0, "R1 reset remainder", rem_a, 0);
    check(rdy_a && rdy_b, "R1 reset ready", rdy_a, 1);
    check(!done_a && !pass_a && !done_b && !pass_b, "R1 reset done/pass", done_a, 0);
  endtask

  task automatic t_small_gen();
    clear_msg(); push_bits(32'b10011010, 8);
    drive_frame(1, 0, 0, 0, 0);
    check(got_rem == 16'h5, "R3 gen 1101 remainder", got_rem, 5);
    check(rdy_low == 3, "R3 ready low K cycles", rdy_low, 3);
    check(lat == 4, "R4 gen done latency", lat, 4);
    check(!got_pass, "R5 no pass in generate mode", got_pass, 0);
    wait_idle();
  endtask

  task automatic t_small_check();
    clear_msg(); push_bits(32'b10011010101, 11);
    drive_frame(1, 1, 0, 0, 0);
    check(got_pass && got_rem == 0, "R5 check good word passes", got_rem, 0);
    check(lat == 1 && rdy_low == 0, "R4 check done latency", lat, 1);
    wait_idle();
    clear_msg(); push_bits(32'b10010110101, 11);
    drive_frame(1, 1, 0, 0, 0);
    check(!got_pass, "R5 check bad word fails", got_pass, 0);
    check(got_rem == 16'h5, "R5 bad word remainder", got_rem, 5);
    wait_idle();
  endtask

  task automatic t_hold();
    logic [15:0] r0;
    clear_msg(); push_bits(32'hA5, 8);
    drive_frame(0, 0, 0, 0, 0);
    r0 = got_rem;
    @(negedge clk);
    check(!done_a, "R4 done is single pulse", done_a, 0);
    repeat (3) @(negedge clk);
    check(rem_a == r0, "R4 remainder holds after done", rem_a, r0);
    wait_idle();
  endtask

  task automatic t_ccitt();
    logic [15:0] c;
    clear_msg();
    for (int b = 0; b < 9; b++) push_bits(32'h31 + b, 8);
    drive_frame(0, 0, 0, 0, 0);
    check(got_rem == 16'h31C3, "R8 default generator check value", got_rem, 16'h31C3);
    check(got_rem == ref_div(GEN_A, 16, 1), "R3 matches reference", got_rem, ref_div(GEN_A, 16, 1));
    check(lat == 17 && rdy_low == 16, "R3 16 zero cycles", rdy_low, 16);
    wait_idle();
    c = got_rem;
    push_bits({16'h0, c}, 16);
    drive_frame(0, 1, 0, 0, 0);
    check(got_pass && got_rem == 0, "R5 CCITT frame with sequence passes", got_rem, 0);
    wait_idle();
    msg[20] = ~msg[20];
    drive_frame(0, 1, 0, 0, 0);
    check(!got_pass && got_rem == ref_div(GEN_A, 16, 0), "R5 corrupted frame fails", got_rem, ref_div(GEN_A, 16, 0));
    wait_idle();
  endtask

  task automatic t_patterns();
    logic [31:0] pats [0:3];
    pats[0] = 32'h0; pats[1] = 32'hFFFFFFFF; pats[2] = 32'h80000001; pats[3] = 32'h1234ABCD;
    for (int p = 0; p < 4; p++) begin
      clear_msg(); push_bits(pats[p], 32);
      drive_frame(0, 0, 0, 0, 0);
      check(got_rem == ref_div(GEN_A, 16, 1), "R2 division step pattern", got_rem, ref_div(GEN_A, 16, 1));
      wait_idle();
    end
    clear_msg(); push_bits(32'h1, 1);
    drive_frame(1, 0, 0, 0, 0);
    check(got_rem == ref_div(GEN_B, 3, 1), "R2 single-bit frame", got_rem, ref_div(GEN_B, 3, 1));
    wait_idle();
  endtask

  task automatic t_ignore();
    clear_msg(); push_bits(32'hC3E1, 16);
    drive_frame(0, 0, 2, 0, 0);
    check(got_rem == ref_div(GEN_A, 16, 1), "R6 idle cycles with markers ignored", got_rem, ref_div(GEN_A, 16, 1));
    wait_idle();
    clear_msg(); push_bits(32'h5B, 8);
    drive_frame(0, 0, 0, 1, 0);
    check(got_rem == ref_div(GEN_A, 16, 1), "R6 beats while not ready ignored", got_rem, ref_div(GEN_A, 16, 1));
    check(rdy_low == 16, "R6 zero insertion not cut short", rdy_low, 16);
    wait_idle();
  endtask

  task automatic t_restart();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      mode_d = 0; valid_d = 1; start_d = (i == 0); last_d = 0; bit_d = 1;
    end
    @(negedge clk); valid_d = 0; start_d = 0;
    clear_msg(); push_bits(32'h6D, 8);
    drive_frame(0, 0, 0, 0, 0);
    check(got_rem == ref_div(GEN_A, 16, 1), "R7 start discards unfinished frame", got_rem, ref_div(GEN_A, 16, 1));
    wait_idle();
    clear_msg(); push_bits(32'b10011010101, 11);
    drive_frame(1, 1, 0, 0, 1);
    check(lat == 1 && got_pass, "R7 mode sampled on start beat", lat, 1);
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_small_gen();
    t_small_check();
    t_hold();
    t_ccitt();
    t_patterns();
    t_ignore();
    t_restart();
    report();
  end

endmodule